// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block turns a set of pending interrupt sources into a single status word. It names the most urgent active source on each of two output paths: a fast path and a normal path. Urgency is not fixed by wiring. Software fills a table of 40 slots. Each slot names one source ID and carries a flag that enables the slot. The slot's position in the table gives its rank, and position 0 is the most urgent.

The surrounding controller supplies three 40-bit vectors: which sources are pending, which are enabled, and which are steered to the fast path. The block keeps its own table and a small register port for writing and reading slots. It derives the status word combinationally from the table and those vectors. Software reads that word to find the source to service on each path. Two sources can win at once, one per path, because each path resolves independently.

Top module: `prio_resolver`

## Requirements
- R1: After reset every table slot reads zero and the status word reads 0x003F003F.
- R2: A slot write keeps only data bit 31 (slot enable) and bits 5:0 (source ID). A read of that slot returns those bits with every other bit zero.
- R3: Slots 0 to 31 are addressed at byte 0x1C + 4*n and slots 32 to 39 at 0xB0 + 4*(n-32). A write to any other address, including a misaligned one, changes no slot. A read of such an address returns zero.
- R4: A slot whose enable bit is clear, or whose source ID is 40 or more, never produces a winner.
- R5: A source competes only when its bit is set in both the pending and the enabled vectors.
- R6: A competing source with its steering bit set competes on the fast path. A competing source with the steering bit clear competes on the normal path.
- R7: On each path, independently, the qualifying slot with the lowest index wins.
- R8: The fast winner's ID is in status bits 5:0 with valid flag bit 15. The normal winner's ID is in bits 21:16 with valid flag bit 31.
- R9: A path with no qualifying slot shows ID 0x3F with its valid flag clear.
- R10: Status bits 14:6 and 30:22 always read zero.
- R11: When several slots name the same source, the lowest qualifying slot decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Byte address of the slot register port |
| regWrEn | input | 1 | Write strobe for the slot register port |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data of the addressed slot |
| pendVec | input | 40 | Pending flag per source |
| enVec | input | 40 | Enable flag per source |
| fastVec | input | 40 | Steering to the fast path per source |
| statusWord | output | 32 | Packed fast and normal winners |

## Verification
The resolution logic is tested with several input patterns, each chosen to tell two behaviours apart:
- One enabled source moved between the two paths, which shows that the steering bit picks the field and valid flag.
- Pending-only and disabled-slot cases, which separate gating on the pending and enabled vectors from gating on the slot contents.
- Four sources in adjacent slots split across both paths, which show that each path picks its own lowest index, and that a higher slot takes over when the winner drops.
- A source named by two slots, which shows that the slot order, not the source number, decides.
Address probes between and off the two slot windows check that decode rejects them.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int NUM_SRC = 40;
  localparam int ID_W    = 6;
  localparam int IDX_W   = 6;

  typedef struct packed {
    logic             wrStb;
    logic             hit;
    logic [IDX_W-1:0] idx;
  } tblStrobe_t;

  typedef struct packed {
    logic            valid;
    logic [ID_W-1:0] srcId;
  } slot_t;
endpackage

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_BASE = 8'h1C,
  parameter logic [ADDR_W-1:0] HI_BASE = 8'hB0,
  parameter int LO_CNT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output tblStrobe_t        strb
);
  localparam int HI_CNT = NUM_SRC - LO_CNT;
  localparam logic [ADDR_W-3:0] LO_LIM = (ADDR_W-2)'(LO_CNT);
  localparam logic [ADDR_W-3:0] HI_LIM = (ADDR_W-2)'(HI_CNT);
  localparam logic [IDX_W-1:0]  HI_OFS = IDX_W'(LO_CNT);

  logic [ADDR_W-1:0] offLo, offHi;
  logic aligned, hitLo, hitHi;

  always_comb begin
    offLo   = regAddr - LO_BASE;
    offHi   = regAddr - HI_BASE;
    aligned = (regAddr[1:0] == 2'b00);
    hitLo   = aligned && (regAddr >= LO_BASE) && (offLo[ADDR_W-1:2] < LO_LIM);
    hitHi   = aligned && (regAddr >= HI_BASE) && (offHi[ADDR_W-1:2] < HI_LIM);
    strb.hit = hitLo || hitHi;
    if (hitHi) strb.idx = HI_OFS + IDX_W'(offHi[ADDR_W-1:2]);
    else if (hitLo) strb.idx = IDX_W'(offLo[ADDR_W-1:2]);
    else strb.idx = '0;
    strb.wrStb = regWrEn && strb.hit;
  end

  AST_HIT_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    strb.hit |-> (regAddr[1:0] == 2'b00)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.hit |-> (int'(strb.idx) < NUM_SRC)); // R3
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |-> regWrEn); // R3
endmodule

// File: rtl/prio_table.sv
module prio_table
  import prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tblStrobe_t         strb,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic [NUM_SRC-1:0] enVec,
  input  logic [NUM_SRC-1:0] fastVec,
  output logic [31:0]        statusWord
);
  localparam logic [ID_W-1:0] SRC_LIM = ID_W'(NUM_SRC);
  localparam int PAD_W = 16 - 1 - ID_W;

  slot_t slotTbl [NUM_SRC];

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) slotTbl[g] <= '0;
        else if (strb.wrStb && (int'(strb.idx) == g))
          slotTbl[g] <= '{valid: regWrData[31], srcId: regWrData[ID_W-1:0]};
      end
    end
  endgenerate

  always_comb begin
    regRdData = '0;
    if (strb.hit) begin
      regRdData[31]     = slotTbl[strb.idx].valid;
      regRdData[ID_W-1:0] = slotTbl[strb.idx].srcId;
    end
  end

  logic            fastVld, normVld;
  logic [ID_W-1:0] fastId, normId;
  logic [ID_W-1:0] curId;
  logic            live;

  always_comb begin
    fastVld = 1'b0;
    normVld = 1'b0;
    fastId  = '1;
    normId  = '1;
    curId   = '0;
    live    = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      curId = slotTbl[i].srcId;
      live  = slotTbl[i].valid && (curId < SRC_LIM) && pendVec[curId] && enVec[curId];
      if (live && fastVec[curId]) begin
        fastVld = 1'b1;
        fastId  = curId;
      end
      if (live && !fastVec[curId]) begin
        normVld = 1'b1;
        normId  = curId;
      end
    end
    statusWord = {normVld, {PAD_W{1'b0}}, normId, fastVld, {PAD_W{1'b0}}, fastId};
  end

  AST_WR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |=> (slotTbl[$past(strb.idx)] == {$past(regWrData[31]), $past(regWrData[ID_W-1:0])})); // R2
  AST_FAST_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[15] |-> (pendVec[statusWord[5:0]] && enVec[statusWord[5:0]] && fastVec[statusWord[5:0]])); // R6
  AST_NORM_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31] |-> (pendVec[statusWord[21:16]] && enVec[statusWord[21:16]] && !fastVec[statusWord[21:16]])); // R5
  AST_EMPTY_FAST: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[15] |-> (statusWord[5:0] == 6'h3F)); // R9
  AST_EMPTY_NORM: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[31] |-> (statusWord[21:16] == 6'h3F)); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[14:6] == '0) && (statusWord[30:22] == '0)); // R10
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [39:0] pendVec,
  input  logic [39:0] enVec,
  input  logic [39:0] fastVec,
  output logic [31:0] statusWord
);
  tblStrobe_t strb;

  prio_ctrl #(.ADDR_W(8)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  prio_table table_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .pendVec(pendVec), .enVec(enVec),
    .fastVec(fastVec), .statusWord(statusWord)
  );
endmodule

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [39:0] pendVec = '0, enVec = '0, fastVec = '0;
  logic [31:0] statusWord;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_resolver dut_i (.*);

  function automatic logic [7:0] slotAddr(int n);
    return (n < 32) ? 8'(8'h1C + 4*n) : 8'(8'hB0 + 4*(n-32));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wrAddr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdAddr(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; #1;
    d = regRdData;
  endtask

  task automatic setSrc(logic [39:0] p, logic [39:0] e, logic [39:0] f);
    @(negedge clk);
    pendVec = p; enVec = e; fastVec = f; #1;
  endtask

  task automatic clearAll();
    for (int n = 0; n < 40; n++) wrAddr(slotAddr(n), 32'h0);
  endtask

  task automatic tReset();
    logic [31:0] d;
    check("R1 status", statusWord, 32'h003F003F);
    rdAddr(slotAddr(0), d);  check("R1 slot0", d, 32'h0);
    rdAddr(slotAddr(39), d); check("R1 slot39", d, 32'h0);
  endtask

  task automatic tWriteMask();
    logic [31:0] d;
    wrAddr(slotAddr(0), 32'hFFFF_FFC5);
    rdAddr(slotAddr(0), d);  check("R2 mask slot0", d, 32'h8000_0005);
    wrAddr(slotAddr(39), 32'h7FFF_FFFF);
    rdAddr(slotAddr(39), d); check("R2 mask slot39", d, 32'h0000_003F);
  endtask

  task automatic tAddrMap();
    logic [31:0] d;
    wrAddr(8'h9C, 32'h8000_0001);
    rdAddr(8'h9C, d);        check("R3 gap read", d, 32'h0);
    rdAddr(slotAddr(31), d); check("R3 slot31 untouched", d, 32'h0);
    rdAddr(slotAddr(32), d); check("R3 slot32 untouched", d, 32'h0);
    wrAddr(8'h1E, 32'h8000_0007);
    rdAddr(slotAddr(0), d);  check("R3 misaligned ignored", d, 32'h8000_0005);
    wrAddr(8'hD0, 32'h8000_0002);
    rdAddr(8'hD0, d);        check("R3 past end read", d, 32'h0);
    wrAddr(slotAddr(33), 32'h8000_0021);
    rdAddr(8'hB4, d);        check("R3 slot33 at B4", d, 32'h8000_0021);
    clearAll();
  endtask

  task automatic tSteer();
    wrAddr(slotAddr(2), 32'h8000_000A);
    setSrc(40'h400, 40'h400, 40'h0);
    check("R8 normal field", statusWord, 32'h800A_003F);
    setSrc(40'h400, 40'h400, 40'h400);
    check("R6 fast field", statusWord, 32'h003F_800A);
  endtask

  task automatic tGate();
    setSrc(40'h400, 40'h0, 40'h0);
    check("R5 pending not enabled", statusWord, 32'h003F_003F);
    setSrc(40'h0, 40'h400, 40'h0);
    check("R5 enabled not pending", statusWord, 32'h003F_003F);
    clearAll();
    wrAddr(slotAddr(3), 32'h0000_000C);
    wrAddr(slotAddr(4), 32'h8000_002D);
    setSrc(40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 40'h0);
    check("R4 disabled or bad id", statusWord, 32'h003F_003F);
    clearAll();
  endtask

  task automatic tOrder();
    wrAddr(slotAddr(5), 32'h8000_0014);
    wrAddr(slotAddr(6), 32'h8000_0015);
    wrAddr(slotAddr(7), 32'h8000_0016);
    wrAddr(slotAddr(8), 32'h8000_0017);
    wrAddr(slotAddr(39), 32'h8000_0000);
    setSrc(40'hF0_0001, 40'hF0_0001, 40'h50_0000);
    check("R7 both paths", statusWord, 32'h8015_8014);
    check("R10 pad bits", statusWord & 32'h7FC0_7FC0, 32'h0);
    setSrc(40'hE0_0001, 40'hF0_0001, 40'h50_0000);
    check("R7 fast next", statusWord, 32'h8015_8016);
    setSrc(40'h40_0001, 40'hF0_0001, 40'h50_0000);
    check("R7 normal slot39 id0", statusWord, 32'h8000_8016);
    clearAll();
  endtask

  task automatic tDup();
    wrAddr(slotAddr(1), 32'h8000_001E);
    wrAddr(slotAddr(2), 32'h8000_001F);
    wrAddr(slotAddr(9), 32'h8000_001E);
    setSrc(40'hC000_0000, 40'hC000_0000, 40'h0);
    check("R11 dup lowest", statusWord, 32'h801E_003F);
    wrAddr(slotAddr(1), 32'h0000_001E);
    check("R11 dup after drop", statusWord, 32'h801F_003F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tWriteMask();
    tAddrMap();
    tSteer();
    tGate();
    tOrder();
    tDup();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule